// File: doc/BRIEF.md
# Dual-Port Load/Store Issue Arbiter

The block holds pending memory operations in a small shared station and, each clock, hands up to two of them to a pair of parallel load/store pipes. Two loads may go out together, or one load with one store. Any pair that would collide falls back to issuing just the older operation. The younger one stays behind for a later cycle. A store that issues pushes one entry into a store buffer. That buffer has a single write port, so no more than one store ever leaves per clock.

Each entry records whether it is a store, its cache index and bank, five attribute bits and a tag. The tag comes back on the grant, so the pipes know which operation they received. Relative age is kept as a per-entry rank: the oldest valid entry holds rank 0 and the next holds rank 1. Selection is therefore strictly oldest-first. Upstream logic is told to hold off through a stall output when every station slot is in use. Downstream logic drains the store buffer through a pop input.

Top module: `ls_dual_issue`

## Requirements
- R1: After a synchronous reset, no grant is valid, `sb_push` is low, and both `stall` and `sb_full` are low.
- R2: Grant 0 always carries the oldest waiting operation and grant 1 the second oldest. Age is the order of acceptance, and grant 1 is never valid without grant 0.
- R3: Two loads that carry no attribute bits issue together in one cycle.
- R4: A load and a store issue together when their index or their bank differs, and no attribute bit is set. `sb_push` is high during that cycle.
- R5: Two stores never issue in the same cycle; only the older one is granted.
- R6: A load and a store with equal index and equal bank issue in separate cycles, older first.
- R7: When either candidate has any of the attribute bits io (bit 0), locked (bit 1), descriptor load (bit 2) or breakpoint (bit 3) set in `enq_attr`, only the older operation issues that cycle.
- R8: When either candidate has the misaligned-first-half bit (bit 4 of `enq_attr`) set, only the older operation issues that cycle.
- R9: While the store buffer holds SB_DEPTH entries, `sb_full` is high and no store is granted. An older store that is blocked also blocks every younger entry. One pop frees a slot for the next cycle.
- R10: `stall` is high exactly while all RS_DEPTH station slots are occupied. An enqueue offered while `stall` is high is dropped and is never granted.
- R11: While `issue_en` is low, no grant is valid, and the station keeps its contents in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_en | input | 1 | Pipes can accept operations this cycle |
| enq_valid | input | 1 | New operation offered to the station |
| enq_is_store | input | 1 | 1 = store, 0 = load |
| enq_idx | input | 6 | Data-cache set index of the operation |
| enq_bank | input | 2 | Data-cache bank of the operation |
| enq_attr | input | 5 | Attribute bits: 0 io, 1 locked, 2 descriptor, 3 breakpoint, 4 misaligned first half |
| enq_tag | input | 4 | Identifier returned with the grant |
| sb_pop | input | 1 | Store buffer drains one entry |
| stall | output | 1 | Station full; enqueues are dropped |
| sb_full | output | 1 | Store buffer holds its maximum |
| sb_push | output | 1 | A granted store enters the store buffer |
| gnt0_valid | output | 1 | Pipe 0 receives an operation |
| gnt0_tag | output | 4 | Tag of the pipe 0 operation |
| gnt0_store | output | 1 | Pipe 0 operation is a store |
| gnt1_valid | output | 1 | Pipe 1 receives an operation |
| gnt1_tag | output | 4 | Tag of the pipe 1 operation |
| gnt1_store | output | 1 | Pipe 1 operation is a store |

## Verification
Every ordered pair of load and store is swept against each of the five attribute bits. Each attribute bit is placed on either the older or the younger candidate. Three address relations are used: a different bank, a different index, and a full match. Together these separate the clean dual-issue cases from each single-issue cause. Running the same pair under every address relation shows that the bank and the index each matter on their own. Running each attribute bit on both sides shows that either candidate can force solo issue. A separate sequence fills the store buffer to show that a blocked store also holds back a younger load, and that one pop releases both. A last sequence fills the station to show that a refused enqueue never reappears as a grant.

// File: rtl/ls_arb_pkg.sv
package ls_arb_pkg;

    localparam int TAG_W  = 4;
    localparam int IDX_W  = 6;
    localparam int BANK_W = 2;
    localparam int ATTR_W = 5;

    // Field order places io at bit 0 and mis_first at bit 4 of the packed value.
    typedef struct packed {
        logic mis_first;
        logic brk;
        logic desc;
        logic locked;
        logic io;
    } ls_attr_t;

    typedef struct packed {
        logic              is_store;
        logic [IDX_W-1:0]  idx;
        logic [BANK_W-1:0] bank;
        ls_attr_t          attr;
        logic [TAG_W-1:0]  tag;
    } ls_op_t;

    function automatic logic needs_solo(ls_attr_t a);
        return a.io | a.locked | a.desc | a.brk | a.mis_first;
    endfunction

    function automatic logic same_line(ls_op_t a, ls_op_t b);
        return (a.idx == b.idx) && (a.bank == b.bank);
    endfunction

    function automatic logic can_pair(ls_op_t a, ls_op_t b);
        logic ok;
        ok = 1'b1;
        if (a.is_store && b.is_store) ok = 1'b0;
        if (needs_solo(a.attr) || needs_solo(b.attr)) ok = 1'b0;
        if ((a.is_store != b.is_store) && same_line(a, b)) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/ls_station.sv
module ls_station
    import ls_arb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   enq_valid,
    input  ls_op_t                                 enq_op,
    input  logic                                   take0,
    input  logic                                   take1,
    output logic [DEPTH-1:0]                       slot_vld,
    output ls_op_t                                 slot_op  [DEPTH],
    output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] slot_rank [DEPTH],
    output logic [$clog2(DEPTH+1)-1:0]             occupancy,
    output logic                                   stall
);
    localparam int RANK_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  n_taken;
    logic [RANK_W-1:0] free_slot;
    logic              free_found;
    logic              enq_ok;
    logic [RANK_W-1:0] new_rank;

    always_comb begin
        occupancy  = '0;
        free_found = 1'b0;
        free_slot  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            occupancy = occupancy + CNT_W'(slot_vld[i]);
            if (!slot_vld[i] && !free_found) begin
                free_found = 1'b1;
                free_slot  = RANK_W'(i);
            end
        end
    end

    assign stall    = (occupancy == CNT_W'(DEPTH));
    assign enq_ok   = enq_valid && !stall;
    assign n_taken  = CNT_W'(take0) + CNT_W'(take1);
    assign new_rank = RANK_W'(occupancy - n_taken);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit;
        assign hit = enq_ok && free_found && (free_slot == RANK_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_vld[g]  <= 1'b0;
                slot_rank[g] <= '0;
            end else begin
                if (slot_vld[g]) begin
                    if (CNT_W'(slot_rank[g]) < n_taken) begin
                        slot_vld[g] <= 1'b0;
                    end else begin
                        slot_rank[g] <= slot_rank[g] - RANK_W'(n_taken);
                    end
                end
                if (hit) begin
                    slot_vld[g]  <= 1'b1;
                    slot_rank[g] <= new_rank;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (hit) slot_op[g] <= enq_op;
        end
    end

endmodule

// File: rtl/ls_pair_pick.sv
module ls_pair_pick
    import ls_arb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0]                             slot_vld,
    input  ls_op_t                                       slot_op   [DEPTH],
    input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] slot_rank [DEPTH],
    input  logic                                         issue_en,
    input  logic                                         sb_full,
    output logic                                         take0,
    output logic                                         take1,
    output ls_op_t                                       op0,
    output ls_op_t                                       op1
);
    localparam int RANK_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic have0, have1;

    always_comb begin
        have0 = 1'b0;
        have1 = 1'b0;
        op0   = '0;
        op1   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_vld[i] && slot_rank[i] == RANK_W'(0)) begin
                have0 = 1'b1;
                op0   = slot_op[i];
            end
            if (slot_vld[i] && slot_rank[i] == RANK_W'(1)) begin
                have1 = 1'b1;
                op1   = slot_op[i];
            end
        end
    end

    always_comb begin
        take0 = issue_en && have0 && !(op0.is_store && sb_full);
        take1 = take0 && have1 && can_pair(op0, op1) && !(op1.is_store && sb_full);
    end

endmodule

// File: rtl/ls_sb_count.sv
module ls_sb_count #(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic                       pop,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic do_pop;
    assign do_pop = pop && (count != '0);
    assign full   = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + CNT_W'(push) - CNT_W'(do_pop);
    end

endmodule

// File: rtl/ls_dual_issue.sv
module ls_dual_issue
    import ls_arb_pkg::*;
#(
    parameter int RS_DEPTH = 4,
    parameter int SB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_en,
    input  logic              enq_valid,
    input  logic              enq_is_store,
    input  logic [IDX_W-1:0]  enq_idx,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic [ATTR_W-1:0] enq_attr,
    input  logic [TAG_W-1:0]  enq_tag,
    input  logic              sb_pop,
    output logic              stall,
    output logic              sb_full,
    output logic              sb_push,
    output logic              gnt0_valid,
    output logic [TAG_W-1:0]  gnt0_tag,
    output logic              gnt0_store,
    output logic              gnt1_valid,
    output logic [TAG_W-1:0]  gnt1_tag,
    output logic              gnt1_store
);
    localparam int RANK_W = (RS_DEPTH > 1) ? $clog2(RS_DEPTH) : 1;
    localparam int OCC_W  = $clog2(RS_DEPTH + 1);
    localparam int SBC_W  = $clog2(SB_DEPTH + 1);

    ls_op_t              new_op;
    logic [RS_DEPTH-1:0] slot_vld;
    ls_op_t              slot_op   [RS_DEPTH];
    logic [RANK_W-1:0]   slot_rank [RS_DEPTH];
    logic [OCC_W-1:0]    occupancy;
    logic                take0, take1;
    ls_op_t              op0, op1;
    logic [SBC_W-1:0]    sb_count;

    always_comb begin
        new_op.is_store = enq_is_store;
        new_op.idx      = enq_idx;
        new_op.bank     = enq_bank;
        new_op.attr     = ls_attr_t'(enq_attr);
        new_op.tag      = enq_tag;
    end

    ls_station #(.DEPTH(RS_DEPTH)) u_station (
        .clk       (clk),
        .rst       (rst),
        .enq_valid (enq_valid),
        .enq_op    (new_op),
        .take0     (take0),
        .take1     (take1),
        .slot_vld  (slot_vld),
        .slot_op   (slot_op),
        .slot_rank (slot_rank),
        .occupancy (occupancy),
        .stall     (stall)
    );

    ls_pair_pick #(.DEPTH(RS_DEPTH)) u_pick (
        .slot_vld  (slot_vld),
        .slot_op   (slot_op),
        .slot_rank (slot_rank),
        .issue_en  (issue_en),
        .sb_full   (sb_full),
        .take0     (take0),
        .take1     (take1),
        .op0       (op0),
        .op1       (op1)
    );

    assign sb_push = (take0 && op0.is_store) || (take1 && op1.is_store);

    ls_sb_count #(.DEPTH(SB_DEPTH)) u_sb (
        .clk   (clk),
        .rst   (rst),
        .push  (sb_push),
        .pop   (sb_pop),
        .count (sb_count),
        .full  (sb_full)
    );

    assign gnt0_valid = take0;
    assign gnt0_tag   = op0.tag;
    assign gnt0_store = op0.is_store;
    assign gnt1_valid = take1;
    assign gnt1_tag   = op1.tag;
    assign gnt1_store = op1.is_store;

endmodule

// File: rtl/ls_dual_issue_chk.sv
module ls_dual_issue_chk
    import ls_arb_pkg::*;
#(
    parameter int RS_DEPTH = 4,
    parameter int SB_DEPTH = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          issue_en,
    input logic                          g0,
    input logic                          g1,
    input ls_op_t                        p0,
    input ls_op_t                        p1,
    input logic                          sbf,
    input logic                          push,
    input logic [$clog2(SB_DEPTH+1)-1:0] sbc,
    input logic [$clog2(RS_DEPTH+1)-1:0] occ,
    input logic                          stl
);
    // R2
    pair_order_chk: assert property (@(posedge clk) disable iff (rst) g1 |-> g0);

    // R5
    no_dual_store_chk: assert property (@(posedge clk) disable iff (rst)
        (g0 && g1) |-> !(p0.is_store && p1.is_store));

    // R6
    no_same_line_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (g1 && (p0.is_store != p1.is_store)) |-> !((p0.idx == p1.idx) && (p0.bank == p1.bank)));

    // R7
    special_solo_chk: assert property (@(posedge clk) disable iff (rst)
        g1 |-> !(p0.attr.io || p0.attr.locked || p0.attr.desc || p0.attr.brk ||
                 p1.attr.io || p1.attr.locked || p1.attr.desc || p1.attr.brk));

    // R8
    misalign_solo_chk: assert property (@(posedge clk) disable iff (rst)
        g1 |-> !(p0.attr.mis_first || p1.attr.mis_first));

    // R9
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (rst) sbf |-> !push);

    // R9
    sb_bound_chk: assert property (@(posedge clk) disable iff (rst)
        sbc <= ($clog2(SB_DEPTH+1))'(SB_DEPTH));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stl && !g0) |=> $stable(occ));

    // R11
    no_issue_when_off_chk: assert property (@(posedge clk) disable iff (rst) !issue_en |-> !g0);

endmodule

bind ls_dual_issue ls_dual_issue_chk #(.RS_DEPTH(RS_DEPTH), .SB_DEPTH(SB_DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .issue_en (issue_en),
    .g0       (take0),
    .g1       (take1),
    .p0       (op0),
    .p1       (op1),
    .sbf      (sb_full),
    .push     (sb_push),
    .sbc      (sb_count),
    .occ      (occupancy),
    .stl      (stall)
);

// File: tb/ls_dual_issue_bench.sv
module ls_dual_issue_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       issue_en = 1'b0;
    logic       enq_valid = 1'b0;
    logic       enq_is_store = 1'b0;
    logic [5:0] enq_idx = '0;
    logic [1:0] enq_bank = '0;
    logic [4:0] enq_attr = '0;
    logic [3:0] enq_tag = '0;
    logic       sb_pop = 1'b0;
    logic       stall, sb_full, sb_push;
    logic       gnt0_valid, gnt0_store, gnt1_valid, gnt1_store;
    logic [3:0] gnt0_tag, gnt1_tag;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] next_tag = '0;

    always #2 clk = ~clk;

    ls_dual_issue u_ls_dual_issue (
        .clk(clk), .rst(rst), .issue_en(issue_en), .enq_valid(enq_valid),
        .enq_is_store(enq_is_store), .enq_idx(enq_idx), .enq_bank(enq_bank),
        .enq_attr(enq_attr), .enq_tag(enq_tag), .sb_pop(sb_pop), .stall(stall),
        .sb_full(sb_full), .sb_push(sb_push), .gnt0_valid(gnt0_valid),
        .gnt0_tag(gnt0_tag), .gnt0_store(gnt0_store), .gnt1_valid(gnt1_valid),
        .gnt1_tag(gnt1_tag), .gnt1_store(gnt1_store)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic enq(input logic st, input logic [5:0] idx, input logic [1:0] bank,
                       input logic [4:0] attr, input logic [3:0] tag);
        enq_valid = 1'b1; enq_is_store = st; enq_idx = idx; enq_bank = bank;
        enq_attr = attr; enq_tag = tag;
        @(negedge clk);
        enq_valid = 1'b0; enq_attr = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1; issue_en = 1'b0; enq_valid = 1'b0; sb_pop = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // addr_rel: 0 bank differs, 1 index differs, 2 index and bank equal
    task automatic run_pair(input int sa, input int sbx, input int f, input int side, input int addr_rel);
        logic [4:0] fa, fb;
        logic [5:0] ib;
        logic [1:0] bb;
        logic [3:0] ta, tb;
        logic dual;
        string req;
        fa = '0; fb = '0;
        if (f != 0) begin
            if (side == 0) fa = 5'(1 << (f - 1));
            else           fb = 5'(1 << (f - 1));
        end
        ib = (addr_rel == 1) ? 6'd9 : 6'd5;
        bb = (addr_rel == 0) ? 2'd2 : 2'd1;
        ta = next_tag; tb = next_tag + 4'd1; next_tag = next_tag + 4'd2;
        dual = !(sa == 1 && sbx == 1) && (f == 0) && !(sa != sbx && addr_rel == 2);
        if (f == 5)                          req = "R8";
        else if (f != 0)                     req = "R7";
        else if (sa == 1 && sbx == 1)        req = "R5";
        else if (sa != sbx && addr_rel == 2) req = "R6";
        else if (sa == 0 && sbx == 0)        req = "R3";
        else                                 req = "R4";
        enq(sa[0], 6'd5, 2'd1, fa, ta);
        enq(sbx[0], ib, bb, fb, tb);
        #1;
        check("R11", "grant while disabled", int'(gnt0_valid), 0);
        issue_en = 1'b1;
        #1;
        check("R2", "oldest on pipe 0", int'(gnt0_valid && gnt0_tag == ta), 1);
        check(req, "second grant", int'(gnt1_valid), int'(dual));
        if (dual) check("R2", "pipe 1 tag", int'(gnt1_tag), int'(tb));
        check(req, "store push", int'(sb_push), int'(sa == 1 || (dual && sbx == 1)));
        @(negedge clk); #1;
        if (!dual) check(req, "younger next cycle", int'(gnt0_valid && gnt0_tag == tb), 1);
        else       check(req, "station drained", int'(gnt0_valid), 0);
        @(negedge clk);
        issue_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        do_reset();
        #1;
        check("R1", "gnt0 after reset", int'(gnt0_valid), 0);
        check("R1", "gnt1 after reset", int'(gnt1_valid), 0);
        check("R1", "sb_push after reset", int'(sb_push), 0);
        check("R1", "stall after reset", int'(stall), 0);
        check("R1", "sb_full after reset", int'(sb_full), 0);
        @(negedge clk);

        // pair sweep with the store buffer draining every cycle
        sb_pop = 1'b1;
        for (int sa = 0; sa < 2; sa++)
            for (int sbx = 0; sbx < 2; sbx++)
                for (int f = 0; f < 6; f++)
                    for (int side = 0; side < 2; side++)
                        for (int ar = 0; ar < 3; ar++)
                            run_pair(sa, sbx, f, side, ar);
        sb_pop = 1'b0;

        // store buffer filling (R9)
        do_reset();
        issue_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            enq(1'b1, 6'(i), 2'd0, 5'd0, 4'(i));
            #1;
            check("R9", "store issues while space", int'(gnt0_valid && gnt0_tag == 4'(i)), 1);
            @(negedge clk);
        end
        #1;
        check("R9", "sb_full after four stores", int'(sb_full), 1);
        issue_en = 1'b0;
        @(negedge clk);
        enq(1'b1, 6'd20, 2'd0, 5'd0, 4'd9);
        enq(1'b0, 6'd21, 2'd0, 5'd0, 4'd10);
        issue_en = 1'b1;
        #1;
        check("R9", "blocked store grant", int'(gnt0_valid), 0);
        check("R9", "younger load held", int'(gnt1_valid), 0);
        @(negedge clk);
        sb_pop = 1'b1;
        @(negedge clk);
        sb_pop = 1'b0;
        #1;
        check("R9", "sb_full after pop", int'(sb_full), 0);
        check("R9", "store after pop", int'(gnt0_valid && gnt0_tag == 4'd9), 1);
        check("R4", "load pairs with store", int'(gnt1_valid && gnt1_tag == 4'd10), 1);
        @(negedge clk); #1;
        check("R9", "full again", int'(sb_full), 1);
        issue_en = 1'b0;

        // station full and dropped enqueue (R10)
        do_reset();
        for (int i = 0; i < 4; i++) begin
            #1;
            check("R10", "stall below capacity", int'(stall), 0);
            enq(1'b0, 6'(i + 1), 2'd3, 5'd0, 4'(i));
        end
        #1;
        check("R10", "stall at capacity", int'(stall), 1);
        enq(1'b0, 6'd40, 2'd3, 5'd0, 4'd7);
        issue_en = 1'b1;
        #1;
        check("R2", "first pair tags", int'(gnt0_tag == 4'd0 && gnt1_tag == 4'd1 && gnt1_valid), 1);
        @(negedge clk); #1;
        check("R2", "second pair tags", int'(gnt0_tag == 4'd2 && gnt1_tag == 4'd3 && gnt1_valid), 1);
        @(negedge clk); #1;
        check("R10", "dropped op never granted", int'(gnt0_valid), 0);
        check("R10", "stall released", int'(stall), 0);
        issue_en = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule